// File: doc/BRIEF.md
# Quadrature Sine/Cosine Generator

This block turns a phase word into a pair of 16-bit samples, the cosine and the sine of the same angle, so the two outputs always form a quadrature pair. Only the upper 16 bits of the phase word are used. The angle is first folded into one quadrant. A fixed-length pipelined CORDIC rotator then produces the result, so no lookup table is stored. The rotator starts from a gain-compensated vector, and the folded quadrant is restored at the output stage.

A run-time select chooses the output coding: signed two's complement, or offset binary, where the sign bit is flipped. A second select chooses how results are delivered. In parallel mode, both words come out together with a one-cycle valid flag. In serial mode, each word is shifted out most significant bit first on its own data line, with a frame pulse that marks the first bit. The pipeline accepts one phase per clock. The valid flag follows a fixed latency.

Top module: `quad_sincos_gen`

## Requirements
- R1: While reset is high and after it is released, `sin_out`, `cos_out`, `out_vld`, `ser_sin`, `ser_cos` and `ser_frame` are all zero.
- R2: For phase word P, with p = P[31:16], `cos_out` and `sin_out` (two's complement) are within ±4 LSB of round(32700·cos(2πp/65536)) and round(32700·sin(2πp/65536)). Their magnitudes never exceed 32700.
- R3: Phase 0 gives cosine near +32700 and sine near 0. Phase 0x4000_0000 (a quarter turn) gives sine near +32700 and cosine near 0, so the vector turns counterclockwise as the phase grows.
- R4: A phase sampled with `phase_vld` high at clock edge k produces exactly one `out_vld` pulse, which is visible after edge k+17 (18 register stages).
- R5: Bits P[15:0] have no effect on the outputs.
- R6: With `fmt_offset` = 0, the outputs are two's complement.
- R7: With `fmt_offset` = 1, each output equals the two's-complement result for the same phase with bit 15 inverted.
- R8: With `ser_mode` = 1, the words are sent on `ser_sin` and `ser_cos` MSB first, one bit per clock, over 16 clocks. The first bit is visible after edge k+18. `ser_frame` is high during the first bit only.
- R9: With `ser_mode` = 1, `out_vld` stays low.
- R10: Phases presented on consecutive clocks produce results on consecutive clocks, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_in | input | 32 | Phase word, full scale equals one turn |
| phase_vld | input | 1 | Phase word valid strobe |
| fmt_offset | input | 1 | 1 selects offset-binary coding, 0 selects two's complement |
| ser_mode | input | 1 | 1 selects bit-serial delivery, 0 selects parallel |
| sin_out | output | 16 | Parallel sine sample |
| cos_out | output | 16 | Parallel cosine sample |
| out_vld | output | 1 | Parallel sample valid |
| ser_sin | output | 1 | Serial sine bit |
| ser_cos | output | 1 | Serial cosine bit |
| ser_frame | output | 1 | High on the first serial bit of a word |

## Verification
The rotator is driven with a back-to-back stream of phases. These include the four axis angles, the four diagonals, and values one step either side of a quadrant boundary, which separate a wrong quadrant mapping or sign from a plain precision loss. Uneven mid-quadrant angles and phases whose low half is nonzero show whether the low bits are truncated and whether the per-stage angle constants are accurate. The same phase is then run through both codings and both delivery modes, so that any difference can only come from the formatting or the serializer.

// File: rtl/qsc_pkg.sv
package qsc_pkg;
  // angle unit inside the rotator: 2^TURN_BITS units per full turn
  localparam int TURN_BITS  = 20;
  localparam int MAX_STAGES = 16;
  // CORDIC gain compensation 1/An in Q30
  localparam longint GAIN_Q30 = 64'd652032874;

  typedef logic [1:0] quad_t;

  // atan(2^-i) expressed in 1/2^TURN_BITS of a turn
  function automatic int atan_units(input int idx);
    case (idx)
      0:  return 131072;
      1:  return 77376;
      2:  return 40884;
      3:  return 20753;
      4:  return 10417;
      5:  return 5213;
      6:  return 2607;
      7:  return 1304;
      8:  return 652;
      9:  return 326;
      10: return 163;
      11: return 81;
      12: return 41;
      13: return 20;
      14: return 10;
      15: return 5;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/qsc_fold.sv
module qsc_fold #(
  parameter int PHASE_W = 32,
  parameter int KEEP_W  = 16,
  parameter int DW      = 21,
  parameter int AW      = 21,
  parameter longint START_X = 317715
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PHASE_W-1:0]   phase,
  input  logic                 vld_i,
  output logic                 vld_o,
  output qsc_pkg::quad_t       quad_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [AW-1:0] z_o
);
  localparam int RES_W = KEEP_W - 2;
  localparam int FRAC  = qsc_pkg::TURN_BITS - KEEP_W;
  localparam int PAD   = AW - RES_W - FRAC;

  logic [RES_W-1:0] resid;
  assign resid = phase[PHASE_W-3 -: RES_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      quad_o <= '0;
      x_o    <= '0;
      y_o    <= '0;
      z_o    <= '0;
    end else begin
      vld_o  <= vld_i;
      quad_o <= phase[PHASE_W-1 -: 2];
      x_o    <= DW'(START_X);
      y_o    <= '0;
      z_o    <= {{PAD{1'b0}}, resid, {FRAC{1'b0}}};
    end
  end
endmodule

// File: rtl/qsc_cordic_stage.sv
module qsc_cordic_stage #(
  parameter int DW  = 21,
  parameter int AW  = 21,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  qsc_pkg::quad_t       quad_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [AW-1:0] z_i,
  output logic                 vld_o,
  output qsc_pkg::quad_t       quad_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [AW-1:0] z_o
);
  localparam logic signed [AW-1:0] STEP = AW'(qsc_pkg::atan_units(IDX));

  logic signed [DW-1:0] xs, ys;
  assign xs = x_i >>> IDX;
  assign ys = y_i >>> IDX;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      quad_o <= '0;
      x_o    <= '0;
      y_o    <= '0;
      z_o    <= '0;
    end else begin
      vld_o  <= vld_i;
      quad_o <= quad_i;
      if (!z_i[AW-1]) begin
        x_o <= x_i - ys;
        y_o <= y_i + xs;
        z_o <= z_i - STEP;
      end else begin
        x_o <= x_i + ys;
        y_o <= y_i - xs;
        z_o <= z_i + STEP;
      end
    end
  end
endmodule

// File: rtl/qsc_out_fmt.sv
module qsc_out_fmt #(
  parameter int DW    = 21,
  parameter int OUT_W = 16,
  parameter int GUARD = 4,
  parameter int AMP   = 32700
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  vld_i,
  input  qsc_pkg::quad_t        quad_i,
  input  logic signed [DW-1:0]  x_i,
  input  logic signed [DW-1:0]  y_i,
  input  logic                  fmt_offset,
  input  logic                  ser_mode,
  output logic [OUT_W-1:0]      sin_o,
  output logic [OUT_W-1:0]      cos_o,
  output logic                  par_vld,
  output logic                  ser_ld
);
  localparam logic signed [DW-1:0] HALF = DW'(1 << (GUARD - 1));
  localparam logic [OUT_W-1:0] FLIP = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [DW-1:0]    xr, yr;
  logic signed [OUT_W-1:0] c_r, s_r, c_m, s_m;

  assign xr  = x_i + HALF;
  assign yr  = y_i + HALF;
  assign c_r = xr[GUARD +: OUT_W];
  assign s_r = yr[GUARD +: OUT_W];

  always_comb begin
    case (quad_i)
      2'd0:    begin c_m = c_r;  s_m = s_r;  end
      2'd1:    begin c_m = -s_r; s_m = c_r;  end
      2'd2:    begin c_m = -c_r; s_m = -s_r; end
      default: begin c_m = s_r;  s_m = -c_r; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_o   <= '0;
      cos_o   <= '0;
      par_vld <= 1'b0;
      ser_ld  <= 1'b0;
    end else begin
      sin_o   <= s_m ^ (fmt_offset ? FLIP : '0);
      cos_o   <= c_m ^ (fmt_offset ? FLIP : '0);
      par_vld <= vld_i & ~ser_mode;
      ser_ld  <= vld_i & ser_mode;
    end
  end

  // R2: rotator result stays within the programmed amplitude
  assert_amp_bound_R2: assert property (@(posedge clk) disable iff (rst)
    vld_i |-> (c_r <= OUT_W'(AMP) && c_r >= -OUT_W'(AMP) &&
               s_r <= OUT_W'(AMP) && s_r >= -OUT_W'(AMP)));
endmodule

// File: rtl/qsc_serializer.sv
module qsc_serializer #(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [OUT_W-1:0] sin_w,
  input  logic [OUT_W-1:0] cos_w,
  output logic             ser_sin,
  output logic             ser_cos,
  output logic             ser_frame
);
  logic [OUT_W-1:0] sh_s, sh_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_s      <= '0;
      sh_c      <= '0;
      ser_frame <= 1'b0;
    end else if (ld) begin
      sh_s      <= sin_w;
      sh_c      <= cos_w;
      ser_frame <= 1'b1;
    end else begin
      sh_s      <= {sh_s[OUT_W-2:0], 1'b0};
      sh_c      <= {sh_c[OUT_W-2:0], 1'b0};
      ser_frame <= 1'b0;
    end
  end

  assign ser_sin = sh_s[OUT_W-1];
  assign ser_cos = sh_c[OUT_W-1];

  // R8: a frame pulse only ever follows a word load
  assert_frame_on_load_R8: assert property (@(posedge clk) disable iff (rst)
    ser_frame |-> $past(ld));
endmodule

// File: rtl/quad_sincos_gen.sv
module quad_sincos_gen #(
  parameter int PHASE_W = 32,
  parameter int OUT_W   = 16,
  parameter int GUARD   = 4,
  parameter int STAGES  = 16,
  parameter int AMP     = 32700
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_in,
  input  logic               phase_vld,
  input  logic               fmt_offset,
  input  logic               ser_mode,
  output logic [OUT_W-1:0]   sin_out,
  output logic [OUT_W-1:0]   cos_out,
  output logic               out_vld,
  output logic               ser_sin,
  output logic               ser_cos,
  output logic               ser_frame
);
  localparam int DW  = OUT_W + GUARD + 1;
  localparam int AW  = qsc_pkg::TURN_BITS + 1;
  localparam int LAT = STAGES + 2;
  localparam longint START_X =
    ((longint'(AMP) << GUARD) * qsc_pkg::GAIN_Q30 + (64'sd1 <<< 29)) >>> 30;

  logic                 vld_p  [0:STAGES];
  qsc_pkg::quad_t       quad_p [0:STAGES];
  logic signed [DW-1:0] x_p    [0:STAGES];
  logic signed [DW-1:0] y_p    [0:STAGES];
  logic signed [AW-1:0] z_p    [0:STAGES];

  logic [OUT_W-1:0] sin_w, cos_w;
  logic             par_vld, ser_ld;

  qsc_fold #(
    .PHASE_W(PHASE_W), .KEEP_W(OUT_W), .DW(DW), .AW(AW), .START_X(START_X)
  ) u_fold (
    .clk(clk), .rst(rst), .phase(phase_in), .vld_i(phase_vld),
    .vld_o(vld_p[0]), .quad_o(quad_p[0]), .x_o(x_p[0]), .y_o(y_p[0]), .z_o(z_p[0])
  );

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    qsc_cordic_stage #(.DW(DW), .AW(AW), .IDX(i)) u_stage (
      .clk(clk), .rst(rst),
      .vld_i(vld_p[i]), .quad_i(quad_p[i]), .x_i(x_p[i]), .y_i(y_p[i]), .z_i(z_p[i]),
      .vld_o(vld_p[i+1]), .quad_o(quad_p[i+1]),
      .x_o(x_p[i+1]), .y_o(y_p[i+1]), .z_o(z_p[i+1])
    );
  end

  qsc_out_fmt #(.DW(DW), .OUT_W(OUT_W), .GUARD(GUARD), .AMP(AMP)) u_fmt (
    .clk(clk), .rst(rst), .vld_i(vld_p[STAGES]), .quad_i(quad_p[STAGES]),
    .x_i(x_p[STAGES]), .y_i(y_p[STAGES]), .fmt_offset(fmt_offset), .ser_mode(ser_mode),
    .sin_o(sin_w), .cos_o(cos_w), .par_vld(par_vld), .ser_ld(ser_ld)
  );

  qsc_serializer #(.OUT_W(OUT_W)) u_ser (
    .clk(clk), .rst(rst), .ld(ser_ld), .sin_w(sin_w), .cos_w(cos_w),
    .ser_sin(ser_sin), .ser_cos(ser_cos), .ser_frame(ser_frame)
  );

  assign sin_out = sin_w;
  assign cos_out = cos_w;
  assign out_vld = par_vld;

  // R4: every parallel result traces back to a strobe exactly LAT edges earlier
  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(phase_vld, LAT));

  // R9: no parallel valid when serial delivery was selected
  assert_par_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(!ser_mode));
endmodule

// File: tb/quad_sincos_gen_tb.sv
module quad_sincos_gen_tb;
  localparam int CLK_PER = 10;
  localparam int AMPL    = 32700;
  localparam int TOL     = 4;
  localparam int NV      = 16;
  localparam logic [31:0] VEC [0:NV-1] = '{
    32'h0000_0000, 32'h4000_0000, 32'h8000_0000, 32'hC000_0000,
    32'h2000_0000, 32'h6000_0000, 32'hA000_0000, 32'hE000_0000,
    32'h1555_0000, 32'h3FFF_0000, 32'h4001_0000, 32'h7FFF_0000,
    32'h9ABC_1234, 32'hCDEF_0000, 32'hFFFF_0000, 32'h05B6_0000
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] phase_in = '0;
  logic        phase_vld = 1'b0;
  logic        fmt_offset = 1'b0;
  logic        ser_mode = 1'b0;
  logic [15:0] sin_out, cos_out;
  logic        out_vld, ser_sin, ser_cos, ser_frame;

  int n_chk = 0;
  int n_bad = 0;
  int n_rcv = 0;
  bit stream_on = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  quad_sincos_gen u_dut (
    .clk(clk), .rst(rst), .phase_in(phase_in), .phase_vld(phase_vld),
    .fmt_offset(fmt_offset), .ser_mode(ser_mode),
    .sin_out(sin_out), .cos_out(cos_out), .out_vld(out_vld),
    .ser_sin(ser_sin), .ser_cos(ser_cos), .ser_frame(ser_frame)
  );

  task automatic chk(input string req, input int act, input int exp, input int tol);
    n_chk++;
    if (act > exp + tol || act < exp - tol) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  function automatic int ref_val(input logic [31:0] p, input bit want_sin);
    real a;
    a = 2.0 * 3.14159265358979 * real'(p[31:16]) / 65536.0;
    return want_sin ? int'($floor(AMPL * $sin(a) + 0.5)) : int'($floor(AMPL * $cos(a) + 0.5));
  endfunction

  // R2, R10: streamed results compared in arrival order
  always @(negedge clk) begin
    if (stream_on && out_vld) begin
      if (n_rcv < NV) begin
        chk("R2 sin", int'($signed(sin_out)), ref_val(VEC[n_rcv], 1'b1), TOL);
        chk("R2 cos", int'($signed(cos_out)), ref_val(VEC[n_rcv], 1'b0), TOL);
      end
      n_rcv++;
    end
  end

  task automatic run_one(input logic [31:0] p, output int s, output int c, output int lat);
    @(negedge clk);
    phase_in = p;
    phase_vld = 1'b1;
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      phase_vld = 1'b0;
      lat++;
      if (out_vld) break;
    end
    s = int'($signed(sin_out));
    c = int'($signed(cos_out));
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int s, c, lat, s2, c2, lat2, cnt;
    logic [15:0] ps, pc, rs, rc;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 sin", int'(sin_out), 0, 0);
    chk("R1 cos", int'(cos_out), 0, 0);
    chk("R1 vld", int'(out_vld), 0, 0);
    chk("R1 frame", int'(ser_frame), 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", int'({out_vld, ser_frame, ser_sin, ser_cos}), 0, 0);

    // R10: back-to-back vector table, R2 compared by the monitor
    stream_on = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      phase_in = VEC[i];
      phase_vld = 1'b1;
    end
    @(negedge clk);
    phase_vld = 1'b0;
    repeat (30) @(negedge clk);
    stream_on = 1'b0;
    chk("R10 result count", n_rcv, NV, 0);

    // R3 and R6: direction of rotation, two's complement coding
    run_one(32'h0000_0000, s, c, lat);
    chk("R3 cos at zero", c, AMPL, TOL);
    chk("R3 sin at zero", s, 0, TOL);
    run_one(32'h4000_0000, s, c, lat);
    chk("R3 sin at quarter", s, AMPL, TOL);
    chk("R3 cos at quarter", c, 0, TOL);
    run_one(32'hD000_0000, s, c, lat);
    chk("R6 negative sin in two's complement", s, ref_val(32'hD000_0000, 1'b1), TOL);

    // R4: latency and single pulse
    run_one(32'h1234_0000, s, c, lat);
    chk("R4 latency", lat, 18, 0);
    @(negedge clk);
    chk("R4 single pulse", int'(out_vld), 0, 0);

    // R5: low phase bits ignored
    run_one(32'h1234_FFFF, s2, c2, lat2);
    chk("R5 sin", s2, s, 0);
    chk("R5 cos", c2, c, 0);

    // R7: offset binary equals two's complement with bit 15 flipped
    run_one(32'hB0F0_0000, s, c, lat);
    fmt_offset = 1'b1;
    run_one(32'hB0F0_0000, s2, c2, lat2);
    chk("R7 sin", int'(s2[15:0]), int'(s[15:0] ^ 16'h8000), 0);
    chk("R7 cos", int'(c2[15:0]), int'(c[15:0] ^ 16'h8000), 0);
    fmt_offset = 1'b0;

    // R8, R9: serial delivery of a known word
    run_one(32'h2AAA_0000, s, c, lat);
    ps = s[15:0];
    pc = c[15:0];
    ser_mode = 1'b1;
    @(negedge clk);
    phase_in = 32'h2AAA_0000;
    phase_vld = 1'b1;
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      phase_vld = 1'b0;
      cnt++;
      chk("R9 parallel valid quiet", int'(out_vld), 0, 0);
      if (ser_frame) break;
    end
    chk("R8 first bit timing", cnt, 19, 0);
    rs = '0;
    rc = '0;
    for (int b = 0; b < 16; b++) begin
      rs = {rs[14:0], ser_sin};
      rc = {rc[14:0], ser_cos};
      if (b > 0) chk("R8 frame only on first bit", int'(ser_frame), 0, 0);
      chk("R9 parallel valid quiet", int'(out_vld), 0, 0);
      @(negedge clk);
    end
    chk("R8 serial sin word", int'(rs), int'(ps), 0);
    chk("R8 serial cos word", int'(rc), int'(pc), 0);
    ser_mode = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule